// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves transmit data out of a ring of descriptors kept in system memory. Software builds the descriptors and sets the ring start address. It holds the controller-enable level high, then pulses the activate input. The engine then reads descriptors one after another. Each descriptor that is marked ready has its buffer streamed out, one byte per beat, on a byte-stream output. The descriptor is then written back with its ready bit cleared, and the engine steps to the next one. It stops at the first descriptor that is not ready and keeps that address, so the next activation resumes there.

Frames can span several descriptors. A descriptor whose last-buffer flag is set closes the frame. Each descriptor carries a wrap flag that sends the walk back to the ring start. If a frame would grow past the configured maximum size, the engine keeps only the bytes that still fit and flags a babbling-transmit error. The frame is not abandoned. The memory port is a plain synchronous port: read data returns on the cycle after the request. Three one-cycle pulses report a consumed buffer, a finished frame and a babble error.

Top module: `txring_dma`

## Requirements
- R1: During and right after reset the engine is idle: `busy` is 0, and `mem_req`, `tx_valid` and all three interrupt pulses are 0. The descriptor pointer and the ring start are both 0.
- R2: A pulse on `kick` starts a walk only while `enable` is 1. `busy` reads 1 from the cycle after an accepted pulse until the walk ends, and then reads 0 again. A pulse while `enable` is 0 has no effect: `busy` stays 0 and memory is not touched.
- R3: A descriptor is 8 bytes. Word 0 at the descriptor address holds the length in bits 15:0 and the flags in bits 31:16: ready is bit 31, wrap is bit 29 and last is bit 27. Word 1 at address + 4 holds the byte address of the buffer. The walk ends at the first fetched descriptor whose ready bit is 0. That descriptor's address is kept as the start of the next walk.
- R4: The buffer bytes go out on `tx_data` in address order, one per `tx_valid` beat. The byte at address a is bits 8*a[1:0]+7 : 8*a[1:0] of the 32-bit word at address a with its low two bits cleared. `tx_last` is 1 on the final byte of a descriptor whose last flag is set.
- R5: Each descriptor consumed is written back to word 0 with bit 31 cleared and all other bits unchanged. Each one also gives one `irq_buf` pulse. The write-back never happens in the same cycle as a stream beat.
- R6: A descriptor with the last flag set gives one `irq_frame` pulse and returns the running frame length to zero.
- R7: Let the running frame length plus a descriptor's length exceed MAX_FRAME. Then only MAX_FRAME minus the running length bytes of that buffer are sent, and one `irq_babble` pulse is given.
- R8: After a descriptor whose wrap flag is set, the next descriptor is fetched from the ring start. Otherwise it is fetched from the current address + 8.
- R9: A write of the ring start via `base_we` stores `base_wdata` with bits 1:0 forced to 0 and loads the pointer with that value. While `enable` is 0, any walk is abandoned and the pointer is reloaded from the ring start.
- R10: The running frame length is zero at the start of every accepted activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable level |
| kick | input | 1 | Transmit activate pulse |
| busy | output | 1 | Activate read-back; 1 while the ring is being walked |
| base_we | input | 1 | Ring start write strobe |
| base_wdata | input | ADDR_W | Ring start value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | A frame byte is on tx_data |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| irq_buf | output | 1 | Buffer consumed pulse |
| irq_frame | output | 1 | Frame finished pulse |
| irq_babble | output | 1 | Frame truncated pulse |

## Verification
A wrong pointer shows up on the ports quickly. The next fetch after the faulty descriptor goes to the wrong address, and a write-back lands on the wrong word in memory, within a few cycles. A stale or unreset frame length shows up only when a later frame is truncated too early. The stream then comes out short and an unexpected `irq_babble` appears, so the bench builds frames near the size limit and checks them across activation boundaries. A wrong byte-lane or count register corrupts the stream at once. The bench compares every byte, every last marker, every interrupt pulse and the whole memory image after each walk.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // Descriptor word 0 layout: length in [15:0], flags in [31:16]
    localparam int LEN_W     = 16;
    localparam int READY_BIT = 31;
    localparam int WRAP_BIT  = 29;
    localparam int LAST_BIT  = 27;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ0,
        ST_HEAD,
        ST_PTR,
        ST_BRD,
        ST_BOUT,
        ST_WB
    } st_e;

endpackage

// File: rtl/txr_clip.sv
// Limits a descriptor's length to the room left in the current frame.
module txr_clip #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 2047,
    parameter int FW        = $clog2(MAX_FRAME + 1)
) (
    input  logic [FW-1:0]    flen,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] take,
    output logic             over
);
    localparam int CW = ((LEN_W > FW) ? LEN_W : FW) + 1;

    logic [CW-1:0] room;
    logic [CW-1:0] need;

    always_comb begin
        room = CW'(MAX_FRAME) - CW'(flen);
        need = CW'(len);
        over = need > room;
        take = over ? LEN_W'(room) : len;
    end
endmodule

// File: rtl/txr_lane.sv
// Picks one byte out of a little-endian 32-bit word.
module txr_lane (
    input  logic [31:0] word_i,
    input  logic [1:0]  sel_i,
    output logic [7:0]  byte_o
);
    assign byte_o = word_i[{sel_i, 3'b000} +: 8];
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 2047
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              kick,
    output logic              busy,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              irq_buf,
    output logic              irq_frame,
    output logic              irq_babble
);
    localparam int FW = $clog2(MAX_FRAME + 1);
    localparam logic [ADDR_W-1:0] DESC_BYTES = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    typedef struct packed {
        st_e              st;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] base;
        logic [31:0]       head;
        logic [ADDR_W-1:0] bufp;
        logic [LEN_W-1:0]  take;
        logic [LEN_W-1:0]  cnt;
        logic [FW-1:0]     flen;
        logic              bab;
    } regs_t;

    regs_t q, d;

    logic [LEN_W-1:0]  clip_take;
    logic              clip_over;
    logic [ADDR_W-1:0] byte_addr;
    logic [7:0]        lane_byte;
    logic              final_beat;

    txr_clip #(
        .LEN_W    (LEN_W),
        .MAX_FRAME(MAX_FRAME),
        .FW       (FW)
    ) u_clip (
        .flen(q.flen),
        .len (mem_rdata[LEN_W-1:0]),
        .take(clip_take),
        .over(clip_over)
    );

    assign byte_addr  = q.bufp + ADDR_W'(q.cnt);
    assign final_beat = (q.cnt == q.take - LEN_W'(1));

    txr_lane u_lane (
        .word_i(mem_rdata),
        .sel_i (byte_addr[1:0]),
        .byte_o(lane_byte)
    );

    always_comb begin
        d          = q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        tx_valid   = 1'b0;
        tx_data    = '0;
        tx_last    = 1'b0;
        irq_buf    = 1'b0;
        irq_frame  = 1'b0;
        irq_babble = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (kick && enable) begin
                    d.st   = ST_REQ0;
                    d.flen = '0;            // R10
                end
            end
            ST_REQ0: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr;
                d.st     = ST_HEAD;
            end
            ST_HEAD: begin
                if (!mem_rdata[READY_BIT]) begin
                    d.st = ST_IDLE;         // R3: pointer left in place
                end else begin
                    d.head   = mem_rdata;
                    d.take   = clip_take;
                    d.bab    = clip_over;
                    mem_req  = 1'b1;
                    mem_addr = q.ptr + WORD_BYTES;
                    d.st     = ST_PTR;
                end
            end
            ST_PTR: begin
                d.bufp = mem_rdata[ADDR_W-1:0];
                d.cnt  = '0;
                d.st   = (q.take == '0) ? ST_WB : ST_BRD;
            end
            ST_BRD: begin
                mem_req  = 1'b1;
                mem_addr = {byte_addr[ADDR_W-1:2], 2'b00};
                d.st     = ST_BOUT;
            end
            ST_BOUT: begin
                tx_valid = 1'b1;
                tx_data  = lane_byte;
                tx_last  = q.head[LAST_BIT] && final_beat;
                d.cnt    = q.cnt + LEN_W'(1);
                d.flen   = q.flen + FW'(1);
                d.st     = final_beat ? ST_WB : ST_BRD;
            end
            ST_WB: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = q.ptr;
                mem_wdata  = q.head & ~(32'h1 << READY_BIT);
                irq_buf    = 1'b1;
                irq_frame  = q.head[LAST_BIT];
                irq_babble = q.bab;
                if (q.head[LAST_BIT]) begin
                    d.flen = '0;
                end
                d.ptr = q.head[WRAP_BIT] ? q.base : q.ptr + DESC_BYTES;
                d.st  = ST_REQ0;
            end
            default: d.st = ST_IDLE;
        endcase

        if (base_we) begin
            d.base = {base_wdata[ADDR_W-1:2], 2'b00};
            d.ptr  = {base_wdata[ADDR_W-1:2], 2'b00};
        end
        if (!enable) begin
            d.st  = ST_IDLE;
            d.ptr = d.base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);

endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       kick,
    input logic       busy,
    input logic       mem_req,
    input logic       mem_we,
    input logic [1:0] addr_lo,
    input logic       wd_ready,
    input logic       tx_valid,
    input logic       irq_buf,
    input logic       irq_frame,
    input logic       irq_babble
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid && !irq_buf));

    // R2
    kick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !enable) |=> !busy);

    // R2
    kick_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && enable && !busy) |=> busy);

    // R5
    wb_ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!wd_ready && irq_buf));

    // R5
    wb_beat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, tx_valid}));

    // R6
    frame_has_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_frame || irq_babble) |-> irq_buf);

    // R9
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (addr_lo == 2'b00));

    // R9
    disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);
endmodule

bind txring_dma txring_dma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .kick      (kick),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .addr_lo   (mem_addr[1:0]),
    .wd_ready  (mem_wdata[31]),
    .tx_valid  (tx_valid),
    .irq_buf   (irq_buf),
    .irq_frame (irq_frame),
    .irq_babble(irq_babble)
);

// File: tb/test_txring_dma.sv
`timescale 1ns/1ps
module test_txring_dma;
    localparam int MAXF = 40;
    localparam int MW   = 256;

    logic        clk = 1'b0;
    logic        rst_n, enable, kick, busy, base_we;
    logic [31:0] base_wdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        irq_buf, irq_frame, irq_babble;

    always #4 clk = ~clk;

    txring_dma #(.ADDR_W(32), .MAX_FRAME(MAXF)) i_txring_dma (
        .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick), .busy(busy),
        .base_we(base_we), .base_wdata(base_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .irq_buf(irq_buf), .irq_frame(irq_frame), .irq_babble(irq_babble)
    );

    logic [31:0] mem [MW];
    logic [31:0] sh  [MW];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    int errors = 0;
    int checks = 0;
    logic [7:0] byte_q[$];
    bit         last_q[$];
    int nbuf, nfrm, nbab;
    logic [7:0] exp_b[$];
    bit         exp_l[$];
    int ebuf, efrm, ebab;
    logic [31:0] mptr, mbase;

    always @(negedge clk) begin
        if (tx_valid) begin
            byte_q.push_back(tx_data);
            last_q.push_back(tx_last);
        end
        if (irq_buf)    nbuf++;
        if (irq_frame)  nfrm++;
        if (irq_babble) nbab++;
    end

    task automatic check(input bit ok, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [15:0] fl,
                            input logic [15:0] len, input logic [31:0] bp);
        mem[a[9:2]] = {fl, len};      sh[a[9:2]] = {fl, len};
        mem[a[9:2] + 8'd1] = bp;      sh[a[9:2] + 8'd1] = bp;
    endtask

    function automatic logic [15:0] flg(input bit rdy, input bit wrp, input bit lst);
        return {rdy, 1'b0, wrp, 1'b0, lst, 11'b0};
    endfunction

    task automatic set_base(input logic [31:0] v);
        @(negedge clk); base_we = 1'b1; base_wdata = v;
        @(negedge clk); base_we = 1'b0;
        mbase = {v[31:2], 2'b00};
        mptr  = mbase;
    endtask

    // Reference walk over the shadow memory
    task automatic model();
        int flen;
        logic [31:0] w0, bp, a, bw;
        int len, room, take;
        flen = 0;
        exp_b.delete(); exp_l.delete();
        ebuf = 0; efrm = 0; ebab = 0;
        for (int it = 0; it < 64; it++) begin
            w0 = sh[mptr[9:2]];
            if (!w0[31]) break;
            len  = int'(w0[15:0]);
            room = MAXF - flen;
            take = (len > room) ? room : len;
            if (len > room) ebab++;
            bp = sh[mptr[9:2] + 8'd1];
            for (int k = 0; k < take; k++) begin
                a  = bp + 32'(k);
                bw = sh[a[9:2]];
                exp_b.push_back(bw[{a[1:0], 3'b000} +: 8]);
                exp_l.push_back(w0[27] && (k == take - 1));
            end
            flen += take;
            if (w0[27]) begin efrm++; flen = 0; end
            ebuf++;
            sh[mptr[9:2]] = w0 & ~32'h8000_0000;
            mptr = w0[29] ? mbase : mptr + 32'd8;
        end
    endtask

    task automatic run(input string tag);
        int bad_b, bad_l, bad_m;
        model();
        byte_q.delete(); last_q.delete();
        nbuf = 0; nfrm = 0; nbab = 0;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        check(busy === 1'b1, "R2 busy read-back after kick", busy, 1);
        while (busy) @(negedge clk);
        check(byte_q.size() == exp_b.size(), {tag, " R4 byte count"}, byte_q.size(), exp_b.size());
        bad_b = 0; bad_l = 0;
        for (int i = 0; i < exp_b.size() && i < byte_q.size(); i++) begin
            if (byte_q[i] !== exp_b[i]) bad_b++;
            if (last_q[i] !== exp_l[i]) bad_l++;
        end
        check(bad_b == 0, {tag, " R4 byte values"}, bad_b, 0);
        check(bad_l == 0, {tag, " R4 last markers"}, bad_l, 0);
        check(nbuf == ebuf, {tag, " R5 buffer pulses"}, nbuf, ebuf);
        check(nfrm == efrm, {tag, " R6 frame pulses"}, nfrm, efrm);
        check(nbab == ebab, {tag, " R7 babble pulses"}, nbab, ebab);
        bad_m = 0;
        for (int i = 0; i < MW; i++) if (mem[i] !== sh[i]) bad_m++;
        check(bad_m == 0, {tag, " R5 R8 memory image"}, bad_m, 0);
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; enable = 1'b0; kick = 1'b0; base_we = 1'b0; base_wdata = '0;
        for (int i = 0; i < MW; i++) begin
            mem[i] = (i >= 128) ? $urandom() : 32'h0;
            sh[i]  = mem[i];
        end
        mbase = 0; mptr = 0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && mem_req === 1'b0 && tx_valid === 1'b0, "R1 idle in reset",
              {busy, mem_req, tx_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && irq_buf === 1'b0 && irq_frame === 1'b0 && irq_babble === 1'b0,
              "R1 idle after reset", {busy, irq_buf, irq_frame, irq_babble}, 0);

        // R2: activation while disabled
        set_base(32'h40);
        put_desc(32'h40, flg(1, 1, 1), 16'd6, 32'h200);
        @(negedge clk); kick = 1'b1; @(negedge clk); kick = 1'b0;
        repeat (4) @(negedge clk);
        check(busy === 1'b0, "R2 kick ignored while disabled", busy, 0);
        check(byte_q.size() == 0, "R2 no stream while disabled", byte_q.size(), 0);
        check(mem[16] === sh[16], "R2 descriptor untouched", mem[16], sh[16]);

        enable = 1'b1;
        run("R2");

        // R3: stop at not-ready, resume there
        set_base(32'h80);
        put_desc(32'h80, flg(1, 0, 0), 16'd5, 32'h210);
        put_desc(32'h88, flg(1, 0, 1), 16'd3, 32'h223);
        put_desc(32'h90, flg(0, 0, 1), 16'd4, 32'h231);
        put_desc(32'h98, flg(0, 1, 1), 16'd2, 32'h242);
        run("R3 first");
        put_desc(32'h90, flg(1, 0, 1), 16'd4, 32'h231);
        put_desc(32'h98, flg(1, 1, 1), 16'd2, 32'h242);
        run("R3 resume");

        // R7: truncation at the frame limit
        set_base(32'hC0);
        put_desc(32'hC0, flg(1, 0, 0), 16'd30, 32'h300);
        put_desc(32'hC8, flg(1, 0, 1), 16'd30, 32'h320);
        put_desc(32'hD0, flg(1, 1, 1), 16'd5,  32'h351);
        run("R7 babble");
        check(ebab == 1 && exp_b.size() == 45, "R7 expected truncation shape", exp_b.size(), 45);

        // R10: frame length restarts per activation
        set_base(32'hC0);
        put_desc(32'hC0, flg(1, 0, 0), 16'd30, 32'h300);
        put_desc(32'hC8, flg(0, 0, 1), 16'd30, 32'h320);
        run("R10 part");
        put_desc(32'hC8, flg(1, 1, 1), 16'd30, 32'h320);
        run("R10 fresh");
        check(nbab == 0, "R10 no babble after new activation", nbab, 0);

        // R9: dropping enable reloads the pointer
        set_base(32'h80);
        put_desc(32'h80, flg(1, 0, 0), 16'd4, 32'h260);
        put_desc(32'h88, flg(0, 1, 1), 16'd4, 32'h270);
        run("R9 part");
        @(negedge clk); enable = 1'b0; @(negedge clk); enable = 1'b1;
        mptr = mbase;
        put_desc(32'h80, flg(1, 0, 0), 16'd4, 32'h260);
        put_desc(32'h88, flg(1, 1, 1), 16'd4, 32'h270);
        run("R9 reload");

        // R8: wrap returns to ring start, skipping a ready descriptor after it
        set_base(32'h43);
        put_desc(32'h40, flg(1, 0, 0), 16'd3, 32'h2A1);
        put_desc(32'h48, flg(1, 1, 1), 16'd7, 32'h2B2);
        put_desc(32'h50, flg(1, 0, 1), 16'd9, 32'h2C0);
        run("R8 wrap");
        check(mem[20][31] === 1'b1, "R8 descriptor beyond wrap left ready", mem[20][31], 1);

        // Random rings
        for (int r = 0; r < 40; r++) begin
            int n, m;
            logic [31:0] b;
            b = 32'h8 * $urandom_range(0, 15) + $urandom_range(0, 3);
            set_base(b);
            n = $urandom_range(1, 6);
            m = $urandom_range(0, n);
            for (int i = 0; i < n; i++)
                put_desc(mbase + 32'(8 * i), flg(i < m, i == n - 1, $urandom_range(0, 1) == 1),
                         16'($urandom_range(0, 30)), 32'h200 + $urandom_range(0, 255));
            run("R9 random ring");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule